// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block generates the control strobes for the multiplexed external bus of an 8-bit controller. It runs on the oscillator clock, and each machine cycle spans a fixed number of oscillator states, twelve by default. A free-running state counter places every strobe edge. At the last state of each machine cycle the block captures a descriptor for the next cycle. The descriptor holds the cycle kind (internal, code fetch, data read or data write), the code address, the low data address, the data-pointer high byte, the port-2 register value, the write data, the high-byte source selection and two configuration inputs.

During the cycle the block drives the following outputs. Address latch enable (ALE) is active high. Program-store enable (PSEN) and the read and write strobes (RD, WR) are active low. Port 2 carries the high address byte. Port 0 carries the low address and then floats or carries the write data, with a separate drive-enable output. A code fetch goes to the external bus if the external-access input is tied low, or if the address lies above the top of internal code space. The upstream sequencer supplies the descriptor; the block does no instruction decoding.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is held, the phase is 0, PSEN, RD and WR are high, port 0 is not driven, port 2 reads all ones, and ALE is high (the reset cycle is internal with ALE allowed).
- R2: The phase counts 0 to STATES-1 and wraps. Inputs present in the clock edge that leaves state STATES-1 define the cycle that starts at state 0.
- R3: In internal and external code-fetch cycles with ALE allowed, ALE is high in states 0,1 and 6,7, which gives two pulses per machine cycle at one sixth of the clock rate.
- R4: In a data read or data write cycle, ALE is high only in states 0,1. The second pulse is omitted.
- R5: In an external code-fetch cycle, PSEN is low in states 3-5 and 9-11. In every other cycle kind PSEN stays high, so both assertions are omitted in data cycles.
- R6: When ale_dis_i=1 and ext_acc_ni=1, ALE stays low for the whole of an internal cycle, including a code fetch that resolves internally. External fetch and data cycles keep their ALE pulses. When ext_acc_ni=0, ale_dis_i has no effect.
- R7: A code fetch is external when ext_acc_ni=0 for any address. When ext_acc_ni=1, it is external only for addresses above INT_TOP (0x0FFF): 0x0FFF is internal and 0x1000 is external.
- R8: RD is low in states 3-8 of a data read cycle and WR is low in states 3-8 of a data write cycle. Otherwise both are high, and they are never low together.
- R9: Port 2 carries the code address high byte in an external fetch. In a data cycle it carries dptr_hi_i when use_dptr_i=1 and p2_reg_i when use_dptr_i=0. In all other cycles it carries p2_reg_i.
- R10: Port 0 drives the low address in states 0-2 of data cycles, and in states 0-2 and 6-8 of external fetch cycles. It drives the write data in states 3-9 of a data write. Otherwise it is not driven and reads 0. Cycle kinds are encoded 0 internal, 1 code fetch, 2 data read, 3 data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cyc_kind_i | input | 2 | Kind of next machine cycle |
| code_addr_i | input | 16 | Code address for a fetch |
| data_lo_i | input | 8 | Low byte of data address (DPTR low or indirect register) |
| dptr_hi_i | input | 8 | Data-pointer high byte |
| p2_reg_i | input | 8 | Port-2 register contents |
| wdata_i | input | 8 | Write data for a data write |
| use_dptr_i | input | 1 | 1: 16-bit pointer access, 0: 8-bit indirect access |
| ale_dis_i | input | 1 | Suppress ALE outside external accesses |
| ext_acc_ni | input | 1 | Low forces all code fetches external |
| phase_o | output | 4 | Current state within the machine cycle |
| ale_o | output | 1 | Address latch enable |
| psen_no | output | 1 | Program-store enable, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| p2_o | output | 8 | High address byte |
| p0_o | output | 8 | Low address / write data |
| p0_oe_o | output | 1 | Port-0 drive enable |

## Verification
The bench builds the block with its defaults: twelve states, two-state ALE pulses and an internal code top of 0x0FFF. With these values a sweep over every cycle kind, both external-access levels, both ALE-disable levels and both high-byte sources is short enough to check every output in every state. The code addresses include 0x0FFF and 0x1000, so the internal/external fetch boundary and the ALE-disable override are both exercised on either side.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_FETCH = 2'd1,
    CYC_DRD   = 2'd2,
    CYC_DWR   = 2'd3
  } cyc_kind_e;

  typedef struct packed {
    cyc_kind_e         kind;
    logic              ext_fetch;
    logic              ale_en;
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] wdat;
  } cyc_desc_t;
endpackage

// File: rtl/bus_phase_ctr.sv
module bus_phase_ctr #(
  parameter int STATES = 12,
  parameter int PH_W   = $clog2(STATES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_o,
  output logic            last_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(STATES - 1);

  assign last_o = (phase_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_o <= '0;
    else if (last_o) phase_o <= '0;
    else             phase_o <= phase_o + 1'b1;
  end

  // R2
  phase_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == LAST) |=> (phase_o == '0));
  // R2
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != LAST) |=> (phase_o == $past(phase_o) + 1'b1));
endmodule

// File: rtl/bus_cycle_latch.sv
module bus_cycle_latch
  import bus_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h0FFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] code_addr_i,
  input  logic [BYTE_W-1:0] data_lo_i,
  input  logic [BYTE_W-1:0] dptr_hi_i,
  input  logic [BYTE_W-1:0] p2_reg_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              use_dptr_i,
  input  logic              ale_dis_i,
  input  logic              ext_acc_ni,
  output cyc_desc_t         desc_o
);
  cyc_kind_e kind;
  logic      is_data, ext_fetch;
  cyc_desc_t nxt;

  assign kind      = cyc_kind_e'(kind_i);
  assign is_data   = (kind == CYC_DRD) || (kind == CYC_DWR);
  assign ext_fetch = (kind == CYC_FETCH) && (!ext_acc_ni || (code_addr_i > INT_TOP));

  always_comb begin
    nxt.kind      = kind;
    nxt.ext_fetch = ext_fetch;
    // disable bit is overridden when every fetch goes external
    nxt.ale_en    = ext_fetch || is_data || !ale_dis_i || !ext_acc_ni;
    nxt.wdat      = wdata_i;
    if (ext_fetch) begin
      nxt.hi = code_addr_i[ADDR_W-1:BYTE_W];
      nxt.lo = code_addr_i[BYTE_W-1:0];
    end else begin
      nxt.hi = (is_data && use_dptr_i) ? dptr_hi_i : p2_reg_i;
      nxt.lo = data_lo_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      desc_o.kind      <= CYC_IDLE;
      desc_o.ext_fetch <= 1'b0;
      desc_o.ale_en    <= 1'b1;
      desc_o.hi        <= '1;
      desc_o.lo        <= '0;
      desc_o.wdat      <= '0;
    end else if (load_i) begin
      desc_o <= nxt;
    end
  end

  // R7
  ext_all_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && kind_i == 2'd1 && !ext_acc_ni) |=> desc_o.ext_fetch);
  // R7
  low_fetch_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && ext_acc_ni && code_addr_i <= INT_TOP) |=> !desc_o.ext_fetch);
endmodule

// File: rtl/bus_strobe_decode.sv
module bus_strobe_decode
  import bus_seq_pkg::*;
#(
  parameter int STATES  = 12,
  parameter int ALE_LEN = 2,
  parameter int PH_W    = $clog2(STATES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PH_W-1:0]   phase_i,
  input  cyc_desc_t         desc_i,
  output logic              ale_o,
  output logic              psen_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic [BYTE_W-1:0] p2_o,
  output logic [BYTE_W-1:0] p0_o,
  output logic              p0_oe_o
);
  localparam int HALF = STATES / 2;
  localparam logic [PH_W-1:0] HALF_P  = PH_W'(HALF);
  localparam logic [PH_W-1:0] ALE_P   = PH_W'(ALE_LEN);
  localparam logic [PH_W-1:0] STRB0_P = PH_W'(ALE_LEN + 1);
  localparam logic [PH_W-1:0] DEND_P  = PH_W'(ALE_LEN + HALF);
  localparam logic [PH_W-1:0] WHOLD_P = PH_W'(ALE_LEN + HALF + 1);

  logic [PH_W-1:0] sub;
  logic is_data, in_dstrb, addr_ph, wdrv;

  assign sub      = (phase_i >= HALF_P) ? phase_i - HALF_P : phase_i;
  assign is_data  = (desc_i.kind == CYC_DRD) || (desc_i.kind == CYC_DWR);
  assign in_dstrb = (phase_i >= STRB0_P) && (phase_i <= DEND_P);
  assign addr_ph  = desc_i.ext_fetch ? (sub <= ALE_P) : (is_data && phase_i <= ALE_P);
  assign wdrv     = (desc_i.kind == CYC_DWR) && (phase_i >= STRB0_P) && (phase_i <= WHOLD_P);

  // data cycles keep only the first pulse
  assign ale_o   = is_data ? (phase_i < ALE_P) : (desc_i.ale_en && sub < ALE_P);
  assign psen_no = !(desc_i.ext_fetch && sub >= STRB0_P);
  assign rd_no   = !((desc_i.kind == CYC_DRD) && in_dstrb);
  assign wr_no   = !((desc_i.kind == CYC_DWR) && in_dstrb);
  assign p2_o    = desc_i.hi;
  assign p0_oe_o = addr_ph || wdrv;
  assign p0_o    = addr_ph ? desc_i.lo : (wdrv ? desc_i.wdat : '0);

  // R4
  data_ale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> !ale_o);
  // R5
  psen_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_no |-> (rd_no && wr_no));
  // R8
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));
  // R10
  psen_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_no |-> !p0_oe_o);
  // R8
  rd_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !p0_oe_o);
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import bus_seq_pkg::*;
#(
  parameter int                STATES  = 12,
  parameter int                ALE_LEN = 2,
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h0FFF,
  parameter int                PH_W    = $clog2(STATES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cyc_kind_i,
  input  logic [ADDR_W-1:0] code_addr_i,
  input  logic [BYTE_W-1:0] data_lo_i,
  input  logic [BYTE_W-1:0] dptr_hi_i,
  input  logic [BYTE_W-1:0] p2_reg_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              use_dptr_i,
  input  logic              ale_dis_i,
  input  logic              ext_acc_ni,
  output logic [PH_W-1:0]   phase_o,
  output logic              ale_o,
  output logic              psen_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic [BYTE_W-1:0] p2_o,
  output logic [BYTE_W-1:0] p0_o,
  output logic              p0_oe_o
);
  logic      last;
  cyc_desc_t desc;

  bus_phase_ctr #(.STATES(STATES), .PH_W(PH_W)) i_ctr (
    .clk_i, .rst_ni, .phase_o, .last_o(last)
  );

  bus_cycle_latch #(.INT_TOP(INT_TOP)) i_latch (
    .clk_i, .rst_ni, .load_i(last), .kind_i(cyc_kind_i), .code_addr_i,
    .data_lo_i, .dptr_hi_i, .p2_reg_i, .wdata_i, .use_dptr_i,
    .ale_dis_i, .ext_acc_ni, .desc_o(desc)
  );

  bus_strobe_decode #(.STATES(STATES), .ALE_LEN(ALE_LEN), .PH_W(PH_W)) i_dec (
    .clk_i, .rst_ni, .phase_i(phase_o), .desc_i(desc), .ale_o, .psen_no,
    .rd_no, .wr_no, .p2_o, .p0_o, .p0_oe_o
  );
endmodule

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cyc_kind = 2'd0;
  logic [15:0] code_addr = '0;
  logic [7:0]  data_lo = '0, dptr_hi = '0, p2_reg = '0, wdata = '0;
  logic        use_dptr = 1'b0, ale_dis = 1'b0, ext_acc_n = 1'b1;
  logic [3:0]  phase;
  logic        ale, psen_n, rd_n, wr_n, p0_oe;
  logic [7:0]  p2, p0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_bus_seq i_ext_bus_seq (
    .clk_i(clk), .rst_ni, .cyc_kind_i(cyc_kind), .code_addr_i(code_addr),
    .data_lo_i(data_lo), .dptr_hi_i(dptr_hi), .p2_reg_i(p2_reg), .wdata_i(wdata),
    .use_dptr_i(use_dptr), .ale_dis_i(ale_dis), .ext_acc_ni(ext_acc_n),
    .phase_o(phase), .ale_o(ale), .psen_no(psen_n), .rd_no(rd_n), .wr_no(wr_n),
    .p2_o(p2), .p0_o(p0), .p0_oe_o(p0_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // one machine cycle: called at a negedge with phase 11, drives the next cycle
  task automatic run_cycle(input logic [1:0] k, input logic [15:0] ca, input logic ud,
                           input logic ad, input logic ean, input int seed);
    logic xf, dat;
    int   sub;
    logic [7:0] lo_v, hi_v, p2_v, dh_v, wd_v;
    logic e_ale, e_psen, e_rd, e_wr, e_oe;
    logic [7:0] e_p2, e_p0;
    lo_v = 8'(8'h30 + seed); dh_v = 8'(8'hA0 ^ seed);
    p2_v = 8'(8'h5C + 3*seed); wd_v = ~8'(seed);
    cyc_kind = k; code_addr = ca; use_dptr = ud; ale_dis = ad; ext_acc_n = ean;
    data_lo = lo_v; dptr_hi = dh_v; p2_reg = p2_v; wdata = wd_v;
    xf  = (k == 2'd1) && (!ean || ca > 16'h0FFF);
    dat = (k == 2'd2) || (k == 2'd3);
    hi_v = xf ? ca[15:8] : ((dat && ud) ? dh_v : p2_v);
    for (int s = 0; s < 12; s++) begin
      @(negedge clk);
      sub    = s % 6;
      e_ale  = dat ? (s < 2) : ((sub < 2) && (xf || !ad || !ean));
      e_psen = !(xf && sub >= 3);
      e_rd   = !(k == 2'd2 && s >= 3 && s <= 8);
      e_wr   = !(k == 2'd3 && s >= 3 && s <= 8);
      e_p2   = hi_v;
      if (xf) begin
        e_oe = (sub <= 2); e_p0 = e_oe ? ca[7:0] : 8'h00;
      end else if (dat) begin
        e_oe = (s <= 2) || (k == 2'd3 && s <= 9);
        e_p0 = (s <= 2) ? lo_v : (e_oe ? wd_v : 8'h00);
      end else begin
        e_oe = 1'b0; e_p0 = 8'h00;
      end
      chk("R2 phase", int'(phase), s);
      chk(dat ? "R4 ale" : (ad ? "R6 ale" : "R3 ale"), int'(ale), int'(e_ale));
      chk((k == 2'd1) ? "R7 psen" : "R5 psen", int'(psen_n), int'(e_psen));
      chk("R8 rd", int'(rd_n), int'(e_rd));
      chk("R8 wr", int'(wr_n), int'(e_wr));
      chk("R9 p2", int'(p2), int'(e_p2));
      chk("R10 p0_oe", int'(p0_oe), int'(e_oe));
      chk("R10 p0", int'(p0), int'(e_p0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] addrs [4];
    int seed;
    addrs[0] = 16'h0FFF; addrs[1] = 16'h1000; addrs[2] = 16'h0000; addrs[3] = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 phase", int'(phase), 0);
    chk("R1 ale", int'(ale), 1);
    chk("R1 psen", int'(psen_n), 1);
    chk("R1 rd", int'(rd_n), 1);
    chk("R1 wr", int'(wr_n), 1);
    chk("R1 p0_oe", int'(p0_oe), 0);
    chk("R1 p2", int'(p2), 8'hFF);
    rst_ni = 1'b1;
    @(negedge clk);
    while (phase != 4'd11) @(negedge clk);
    seed = 0;
    for (int k = 0; k < 4; k++)
      for (int e = 0; e < 2; e++)
        for (int a = 0; a < 2; a++)
          for (int u = 0; u < 2; u++)
            for (int i = 0; i < 4; i++) begin
              run_cycle(2'(k), addrs[i], u[0], a[0], e[0], seed);
              seed++;
            end
    // back-to-back data read then data write, both pointer sources
    run_cycle(2'd2, 16'h1234, 1'b1, 1'b1, 1'b1, 7);
    run_cycle(2'd3, 16'h1234, 1'b0, 1'b1, 1'b1, 9);
    run_cycle(2'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 11);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule